// File: doc/BRIEF.md
# Interrupt Priority Level Controller

This block decides when the processor leaves its current work to service an interrupt. It keeps the running priority level, which is 0 for ordinary program code. It collects pending requests at levels 1 to 31. Hardware request lines map to the upper sixteen levels, 16 to 31. Software request bits map to the lower levels, 1 to 15. Whenever the highest pending level is strictly above the running level, the controller takes that interrupt. It announces the take with a one-cycle pulse that carries the level, and from then on the service code runs at that level.

The level that was running before each take is pushed onto a small last-in-first-out stack. A return pulse pops the stack and restores that level. On the very next clock, the pending requests are judged again against the restored level.

The sequencer has two states. `S_ARB` evaluates requests and returns on every clock. `S_GRANT` lasts one cycle and drives the take pulse. The transitions are:
- `S_ARB` goes to `S_GRANT` on a take.
- `S_ARB` stays in `S_ARB` on a return, or when nothing is taken.
- `S_GRANT` always goes back to `S_ARB`.

A return has priority over a take in the same `S_ARB` cycle. A return that arrives during `S_GRANT` is ignored.

Top module: `ipl_ctrl`

## Requirements
- R1: After reset, `cur_level` is 0, `take_irq` is 0, `stack_ovf` is 0 and no software request is pending.
- R2: `hw_req[i]` requests level 16+i. A `sw_set_valid` pulse with `sw_set_level` in 1..15 makes that software level pending. A `sw_set_valid` pulse with level 0, or with level 16 or above, has no effect.
- R3: A software request set at clock edge E is arbitrated at edge E+1. After that edge, `take_irq` is high for exactly one cycle, and `take_level` and `cur_level` both equal the taken level. A hardware request is taken at the first edge where it is high.
- R4: A pending level that is equal to or lower than `cur_level` is never taken.
- R5: When several requests are pending, the highest level is taken first.
- R6: A return (`irq_ret` high in `S_ARB`) restores the level that was running before the most recent take still on the stack. With an empty stack, `cur_level` is unchanged.
- R7: After a return, requests are judged against the restored level at the next edge. A request still above that level is taken one cycle after the return.
- R8: A software pending bit clears when its level is taken. A hardware line is level-sensitive, so a line still high after a return is taken again.
- R9: The stack holds 8 levels. A take made while the stack is full still raises the level, but the previous level is not stored, and `stack_ovf` becomes 1 and stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hw_req | input | 16 | Level-sensitive hardware requests; bit i is level 16+i |
| sw_set_valid | input | 1 | Strobe that marks a software level as pending |
| sw_set_level | input | 5 | Software level to mark (1..15 accepted) |
| irq_ret | input | 1 | Return from the current service code |
| take_irq | output | 1 | One-cycle pulse: an interrupt is taken |
| take_level | output | 5 | Level of the taken interrupt |
| cur_level | output | 5 | Running priority level |
| stack_ovf | output | 1 | Sticky flag: a previous level was lost to a full stack |

## Verification
A wrong level on the stack does not show at the take; it shows only at a later return, where `cur_level` lands on the wrong value on the cycle after the pulse. The next take or missed take, one cycle later, then exposes it further. A software bit that fails to clear shows as a duplicate take on the cycle after the next return to a lower level. A lost hardware request shows as a missing take on the cycle after a return. For these reasons the bench checks `cur_level` after every return, and the scoreboard treats any take it did not expect as a failure.

// File: rtl/ipl_pkg.sv
package ipl_pkg;
    typedef enum logic [0:0] {
        S_ARB   = 1'b0,
        S_GRANT = 1'b1
    } ipl_state_e;
endpackage

// File: rtl/ipl_sw_pending.sv
module ipl_sw_pending #(
    parameter int LVL_W = 5,
    localparam int HALF = 2 ** (LVL_W - 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_valid,
    input  logic [LVL_W-1:0] set_level,
    input  logic             clr_valid,
    input  logic [LVL_W-1:0] clr_level,
    output logic [HALF-1:0]  pend
);
    // level 0 is the base level and never pending; upper half is hardware
    logic set_ok;
    assign set_ok  = set_valid && !set_level[LVL_W-1] && (set_level != '0);
    assign pend[0] = 1'b0;

    for (genvar i = 1; i < HALF; i++) begin : g_bit
        logic bit_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                bit_q <= 1'b0;
            else if (set_ok && set_level == LVL_W'(i))
                bit_q <= 1'b1;
            else if (clr_valid && clr_level == LVL_W'(i))
                bit_q <= 1'b0;
        end
        assign pend[i] = bit_q;
    end
endmodule

// File: rtl/ipl_arbiter.sv
module ipl_arbiter #(
    parameter int LVL_W = 5,
    localparam int NUM_LVL = 2 ** LVL_W
) (
    input  logic [NUM_LVL-1:0] req,
    output logic               win_valid,
    output logic [LVL_W-1:0]   win_level
);
    always_comb begin
        win_valid = 1'b0;
        win_level = '0;
        for (int i = 0; i < NUM_LVL; i++) begin
            if (req[i]) begin
                win_valid = 1'b1;
                win_level = LVL_W'(i);
            end
        end
    end
endmodule

// File: rtl/ipl_stack.sv
module ipl_stack #(
    parameter int LVL_W = 5,
    parameter int DEPTH = 8,
    localparam int CW = $clog2(DEPTH + 1),
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [LVL_W-1:0] din,
    input  logic             pop,
    output logic [LVL_W-1:0] top,
    output logic             empty,
    output logic             full
);
    logic [LVL_W-1:0] mem [DEPTH];
    logic [CW-1:0]    cnt;

    assign empty = (cnt == '0);
    assign full  = (cnt == CW'(DEPTH));
    assign top   = mem[PW'(cnt - 1'b1)];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (push && !full) begin
            mem[PW'(cnt)] <= din;
            cnt           <= cnt + 1'b1;
        end else if (pop && !empty) begin
            cnt <= cnt - 1'b1;
        end
    end

    p_count_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH));
    p_no_push_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full) |=> (cnt == CW'(DEPTH)));
endmodule

// File: rtl/ipl_ctrl.sv
module ipl_ctrl
    import ipl_pkg::*;
#(
    parameter int LVL_W       = 5,
    parameter int STACK_DEPTH = 8,
    localparam int NUM_LVL = 2 ** LVL_W,
    localparam int HALF    = NUM_LVL / 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [HALF-1:0]  hw_req,
    input  logic             sw_set_valid,
    input  logic [LVL_W-1:0] sw_set_level,
    input  logic             irq_ret,
    output logic             take_irq,
    output logic [LVL_W-1:0] take_level,
    output logic [LVL_W-1:0] cur_level,
    output logic             stack_ovf
);
    ipl_state_e       state_q, state_d;
    logic [LVL_W-1:0] cur_q;
    logic             ovf_q;
    logic [HALF-1:0]  sw_pend;
    logic             win_valid;
    logic [LVL_W-1:0] win_level;
    logic [LVL_W-1:0] stk_top;
    logic             stk_empty, stk_full;
    logic             do_ret, do_take;

    ipl_sw_pending #(.LVL_W(LVL_W)) u_swp (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_valid (sw_set_valid),
        .set_level (sw_set_level),
        .clr_valid (do_take && !win_level[LVL_W-1]),
        .clr_level (win_level),
        .pend      (sw_pend)
    );

    ipl_arbiter #(.LVL_W(LVL_W)) u_arb (
        .req       ({hw_req, sw_pend}),
        .win_valid (win_valid),
        .win_level (win_level)
    );

    ipl_stack #(.LVL_W(LVL_W), .DEPTH(STACK_DEPTH)) u_stk (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (do_take && !stk_full),
        .din   (cur_q),
        .pop   (do_ret),
        .top   (stk_top),
        .empty (stk_empty),
        .full  (stk_full)
    );

    // return beats a take in the same arbitration cycle
    assign do_ret  = (state_q == S_ARB) && irq_ret;
    assign do_take = (state_q == S_ARB) && !irq_ret && win_valid && (win_level > cur_q);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_ARB:   if (do_take) state_d = S_GRANT;
            S_GRANT: state_d = S_ARB;
            default: state_d = S_ARB;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_ARB;
            cur_q   <= '0;
            ovf_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (do_take)
                cur_q <= win_level;
            else if (do_ret && !stk_empty)
                cur_q <= stk_top;
            if (do_take && stk_full)
                ovf_q <= 1'b1;
        end
    end

    always_comb begin
        take_irq   = (state_q == S_GRANT);
        take_level = cur_q;
        cur_level  = cur_q;
        stack_ovf  = ovf_q;
    end

    p_take_raises_r3: assert property (@(posedge clk) disable iff (!rst_n)
        do_take |=> (take_irq && cur_level == $past(win_level)));
    p_grant_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        take_irq |=> !take_irq);
    p_strictly_above_r4: assert property (@(posedge clk) disable iff (!rst_n)
        take_irq |-> (take_level > $past(cur_level)));
    p_empty_ret_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (do_ret && stk_empty) |=> $stable(cur_level));
    p_sw_cleared_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (take_irq && !take_level[LVL_W-1] &&
         !$past(sw_set_valid && sw_set_level == take_level))
        |-> !sw_pend[take_level[LVL_W-2:0]]);
    p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stack_ovf |=> stack_ovf);
endmodule

// File: tb/ipl_ctrl_tb.sv
module ipl_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] hw_req = '0;
    logic        sw_set_valid = 1'b0;
    logic [4:0]  sw_set_level = '0;
    logic        irq_ret = 1'b0;
    logic        take_irq;
    logic [4:0]  take_level;
    logic [4:0]  cur_level;
    logic        stack_ovf;

    int n_tests = 0;
    int n_fail  = 0;
    int exp_q[$];

    always #10 clk = ~clk;

    ipl_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .hw_req(hw_req),
        .sw_set_valid(sw_set_valid), .sw_set_level(sw_set_level),
        .irq_ret(irq_ret), .take_irq(take_irq), .take_level(take_level),
        .cur_level(cur_level), .stack_ovf(stack_ovf)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic sw_req(input int lvl);
        sw_set_valid = 1'b1;
        sw_set_level = 5'(lvl);
        tick();
        sw_set_valid = 1'b0;
    endtask

    task automatic do_return();
        irq_ret = 1'b1;
        tick();
        irq_ret = 1'b0;
    endtask

    // scoreboard monitor: every take must match the head of the queue
    always @(negedge clk) begin : mon
        int e;
        if (rst_n && take_irq) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R4 unexpected take", int'(take_level), -1);
            end else begin
                e = exp_q.pop_front();
                check(int'(take_level) == e, "R5 take order", int'(take_level), e);
                check(cur_level == take_level, "R3 level raised", int'(cur_level), int'(take_level));
            end
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_fail++;
        n_tests++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : stim
        tick(2);
        rst_n = 1'b1;
        tick();
        // R1 reset state
        check(cur_level == 0, "R1 cur_level", int'(cur_level), 0);
        check(!take_irq, "R1 take_irq", int'(take_irq), 0);
        check(!stack_ovf, "R1 stack_ovf", int'(stack_ovf), 0);
        tick(3);   // no pending software level: monitor sees no take

        // R6 return with empty stack
        do_return();
        check(cur_level == 0, "R6 empty return", int'(cur_level), 0);

        // R3 exact timing of a software take
        exp_q.push_back(5);
        sw_req(5);
        check(!take_irq, "R3 not yet taken", int'(take_irq), 0);
        tick();
        check(take_irq && take_level == 5, "R3 take pulse", int'(take_level), 5);
        tick();
        check(!take_irq, "R3 single pulse", int'(take_irq), 0);

        // R4 lower and equal levels are held off
        sw_req(3);
        sw_req(5);
        tick(3);
        check(cur_level == 5, "R4 level held", int'(cur_level), 5);

        // R6 restore, R7 re-evaluation, R5 highest first
        exp_q.push_back(5);
        exp_q.push_back(3);
        do_return();
        check(cur_level == 0, "R6 restored", int'(cur_level), 0);
        tick();
        check(take_irq && take_level == 5, "R7 retake next clock", int'(take_level), 5);
        tick();
        do_return();
        check(cur_level == 0, "R6 restored again", int'(cur_level), 0);
        tick();
        check(cur_level == 3, "R7 lower level next", int'(cur_level), 3);
        tick();
        do_return();
        check(cur_level == 0, "R8 sw bits cleared", int'(cur_level), 0);
        tick(3);

        // R2 and R8 hardware line, level-sensitive
        exp_q.push_back(18);
        hw_req[2] = 1'b1;
        tick();
        check(take_irq && take_level == 18, "R2 hw line maps to 18", int'(take_level), 18);
        tick(3);
        exp_q.push_back(18);
        do_return();
        check(cur_level == 0, "R6 restore under hw", int'(cur_level), 0);
        tick();
        check(cur_level == 18, "R8 hw retaken", int'(cur_level), 18);
        hw_req[2] = 1'b0;
        tick();
        do_return();
        check(cur_level == 0, "R6 hw released", int'(cur_level), 0);
        tick(3);

        // R5 hardware and software raised together
        exp_q.push_back(16);
        exp_q.push_back(10);
        hw_req[0]    = 1'b1;
        sw_set_valid = 1'b1;
        sw_set_level = 5'd10;
        tick();
        sw_set_valid = 1'b0;
        hw_req[0]    = 1'b0;
        tick(2);
        check(cur_level == 16, "R5 hw wins", int'(cur_level), 16);
        do_return();
        tick();
        check(cur_level == 10, "R5 sw after hw", int'(cur_level), 10);
        tick();
        do_return();
        check(cur_level == 0, "R6 back to base", int'(cur_level), 0);

        // R2 ignored software levels
        sw_req(0);
        sw_req(20);
        tick(4);
        check(cur_level == 0, "R2 invalid sw levels", int'(cur_level), 0);

        // R9 nesting beyond the stack
        for (int k = 1; k <= 9; k++) begin
            exp_q.push_back(k);
            sw_req(k);
            tick(2);
        end
        check(cur_level == 9, "R9 deepest level", int'(cur_level), 9);
        check(stack_ovf, "R9 overflow flag", int'(stack_ovf), 1);
        do_return();
        check(cur_level == 7, "R9 lost level", int'(cur_level), 7);
        for (int k = 6; k >= 0; k--) begin
            do_return();
            check(cur_level == 5'(k), "R9 unwind", int'(cur_level), k);
        end
        do_return();
        check(cur_level == 0, "R6 empty after unwind", int'(cur_level), 0);
        check(stack_ovf, "R9 flag sticky", int'(stack_ovf), 1);

        tick(3);
        check(exp_q.size() == 0, "R3 all takes seen", exp_q.size(), 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule